// File: doc/BRIEF.md
# Gray-Scale Dither Pattern Mapper

This block turns 2-bit pixel codes into single on/off dots for a binary passive panel, so that the panel shows four perceived intensity levels. The darkest and brightest codes go straight through as a constant dot state. Each of the two middle codes is looked up in its own writable pattern table. A table holds sixteen 4×4 dot patterns, and the table to use is picked by the frame phase.

The timing generator supplies a pixel code together with its row, column and frame counters and a valid strobe. The block returns one dot one clock later. A host writes the tables a byte at a time through a simple write port. The patterns set how each middle level is spread over space and time.

Top module: `gray_dither_map`

## Requirements
- R1: After reset every pattern table bit is 0, `dotOut` is 0 and `dotValid` is 0. Until the tables are written, codes 01 and 10 therefore give an off dot.
- R2: A valid pixel with code 00 gives `dotOut` = 0, whatever the row, column and frame.
- R3: A valid pixel with code 11 gives `dotOut` = 1, whatever the row, column and frame.
- R4: Code 01 reads its dot from table 0, and code 10 reads its dot from table 1.
- R5: The pattern used within a table is the frame counter modulo 16.
- R6: Within a 16-bit pattern, the dot is bit number (row mod 4)·4 + (column mod 4).
- R7: The write address `wrAddr` is 6 bits wide and is split into three fields:
  - bit 5 selects the table.
  - bits 4:1 select the pattern.
  - bit 0 selects the byte. Byte 0 holds pattern bits 7:0 and byte 1 holds bits 15:8.
- R8: `dotValid` repeats `pixValid` with one clock of latency. `dotOut` belongs to the pixel presented one clock earlier and is 0 when that pixel was not valid.
- R9: When `wrEn` is low, `wrAddr` and `wrData` have no effect on the tables.
- R10: A byte written at a clock edge is seen by pixels sampled at later edges. A pixel sampled at the same edge as the write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table byte write strobe |
| wrAddr | input | 6 | Table byte address (table, pattern, byte) |
| wrData | input | 8 | Table byte value |
| pixValid | input | 1 | Pixel code and counters are valid |
| pixCode | input | 2 | Pixel intensity code |
| rowCnt | input | 9 | Row counter from the timing generator |
| colCnt | input | 10 | Column counter from the timing generator |
| frameCnt | input | 8 | Frame counter from the timing generator |
| dotOut | output | 1 | Mapped dot, registered |
| dotValid | output | 1 | Registered valid for `dotOut` |

## Verification
The in-RTL assertions check the following on every cycle:
- codes 00 and 11 give a constant dot one cycle later;
- `dotValid` and the forced-off output follow `pixValid`;
- the table storage stays unchanged in any cycle without a write strobe;
- a middle code always starts a table lookup.

The bench scenarios cover what needs a reference model of the table contents:
- the bit selected by row and column;
- the phase taken from the frame counter, including counters beyond their modulus;
- the placement of low and high bytes;
- the separation of the two tables;
- the old-data result when a write and a lookup share an edge.

// File: rtl/gray_dither_pkg.sv
package gray_dither_pkg;
  localparam int PAT_SIDE  = 4;
  localparam int PHASES    = 16;
  localparam int TABLES    = 2;
  localparam int BYTE_W    = 8;
  localparam int SIDE_W    = $clog2(PAT_SIDE);
  localparam int PHASE_W   = $clog2(PHASES);
  localparam int TBL_W     = (TABLES > 1) ? $clog2(TABLES) : 1;
  localparam int PAT_BITS  = PAT_SIDE * PAT_SIDE;
  localparam int BIT_W     = $clog2(PAT_BITS);
  localparam int PAT_BYTES = PAT_BITS / BYTE_W;
  localparam int SEL_W     = (PAT_BYTES > 1) ? $clog2(PAT_BYTES) : 1;
  localparam int ADDR_W    = TBL_W + PHASE_W + SEL_W;

  typedef struct packed {
    logic [TABLES-1:0]  tblWr;
    logic [PHASE_W-1:0] wrPat;
    logic [SEL_W-1:0]   wrSel;
    logic [BYTE_W-1:0]  wrByte;
    logic               pixGo;
    logic               forceOn;
    logic               lookEn;
    logic [TBL_W-1:0]   lookTbl;
    logic [PHASE_W-1:0] lookPat;
    logic [BIT_W-1:0]   lookBit;
  } ditherStrobe_t;
endpackage

// File: rtl/gray_dither_ctrl.sv
module gray_dither_ctrl
  import gray_dither_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 10,
  parameter int FRAME_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                pixValid,
  input  logic [1:0]          pixCode,
  input  logic [ROW_W-1:0]    rowCnt,
  input  logic [COL_W-1:0]    colCnt,
  input  logic [FRAME_W-1:0]  frameCnt,
  output ditherStrobe_t       strb
);
  logic [TBL_W-1:0] wrTbl;

  assign wrTbl = wrAddr[ADDR_W-1 -: TBL_W];

  always_comb begin
    strb = '0;
    // host side: decode the byte address into per-table strobes
    for (int t = 0; t < TABLES; t++) begin
      strb.tblWr[t] = wrEn && (wrTbl == TBL_W'(t));
    end
    strb.wrPat  = wrAddr[SEL_W +: PHASE_W];
    strb.wrSel  = wrAddr[SEL_W-1:0];
    strb.wrByte = wrData;
    // pixel side: classify the code and form the lookup coordinates
    strb.pixGo   = pixValid;
    strb.forceOn = pixValid && (pixCode == 2'b11);
    strb.lookEn  = pixValid && (pixCode == 2'b01 || pixCode == 2'b10);
    strb.lookTbl = TBL_W'(pixCode == 2'b10);
    strb.lookPat = frameCnt[PHASE_W-1:0];
    strb.lookBit = {rowCnt[SIDE_W-1:0], colCnt[SIDE_W-1:0]};
  end

  // R4
  mid_code_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (pixCode == 2'b01 || pixCode == 2'b10)) |-> (strb.lookEn && !strb.forceOn));
endmodule

// File: rtl/gray_dither_data.sv
module gray_dither_data
  import gray_dither_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ditherStrobe_t strb,
  output logic          dotOut,
  output logic          dotValid
);
  logic [TABLES-1:0][PHASES-1:0][PAT_BITS-1:0] patMem;

  for (genvar t = 0; t < TABLES; t++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        patMem[t] <= '0;
      end else if (strb.tblWr[t]) begin
        patMem[t][strb.wrPat][BYTE_W*strb.wrSel +: BYTE_W] <= strb.wrByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotOut   <= 1'b0;
      dotValid <= 1'b0;
    end else begin
      dotValid <= strb.pixGo;
      dotOut   <= strb.forceOn ||
                  (strb.lookEn && patMem[strb.lookTbl][strb.lookPat][strb.lookBit]);
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pixGo |=> dotValid);
  // R8
  idle_dot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pixGo |=> (!dotValid && !dotOut));
  // R3
  force_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOn |=> dotOut);
  // R2
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pixGo && !strb.forceOn && !strb.lookEn) |=> !dotOut);
  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tblWr == '0) |=> $stable(patMem));
endmodule

// File: rtl/gray_dither_map.sv
module gray_dither_map
  import gray_dither_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 10,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               pixValid,
  input  logic [1:0]         pixCode,
  input  logic [ROW_W-1:0]   rowCnt,
  input  logic [COL_W-1:0]   colCnt,
  input  logic [FRAME_W-1:0] frameCnt,
  output logic               dotOut,
  output logic               dotValid
);
  ditherStrobe_t strb;

  gray_dither_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .FRAME_W(FRAME_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixValid(pixValid), .pixCode(pixCode), .rowCnt(rowCnt), .colCnt(colCnt),
    .frameCnt(frameCnt), .strb(strb)
  );

  gray_dither_data i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dotOut(dotOut), .dotValid(dotValid)
  );
endmodule

// File: tb/test_gray_dither_map.sv
module test_gray_dither_map;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pixValid = 1'b0;
  logic [1:0] pixCode = '0;
  logic [8:0] rowCnt = '0;
  logic [9:0] colCnt = '0;
  logic [7:0] frameCnt = '0;
  logic       dotOut, dotValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model [2][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_dither_map i_gray_dither_map (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixValid(pixValid), .pixCode(pixCode), .rowCnt(rowCnt), .colCnt(colCnt),
    .frameCnt(frameCnt), .dotOut(dotOut), .dotValid(dotValid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeByte(input bit tbl, input int pat, input bit hi, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {tbl, 4'(pat), hi}; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    if (hi) model[tbl][pat][15:8] = val; else model[tbl][pat][7:0] = val;
  endtask

  function automatic logic expDot(input logic [1:0] code, input int row, input int col, input int frm);
    if (code == 2'b00) return 1'b0;
    if (code == 2'b11) return 1'b1;
    return model[code == 2'b10][frm % 16][(row % 4) * 4 + (col % 4)];
  endfunction

  task automatic pixel(input string req, input logic [1:0] code, input int row, input int col, input int frm);
    @(negedge clk);
    pixValid = 1'b1; pixCode = code; rowCnt = 9'(row); colCnt = 10'(col); frameCnt = 8'(frm);
    @(negedge clk);
    pixValid = 1'b0;
    check(req, dotOut, expDot(code, row, col, frm));
    check("R8", dotValid, 1'b1);
  endtask

  task automatic testReset();
    check("R1", dotOut, 1'b0);
    check("R1", dotValid, 1'b0);
    for (int i = 0; i < 16; i++) pixel("R1", 2'b01, i / 4, i % 4, i);
    pixel("R1", 2'b10, 3, 3, 15);
  endtask

  task automatic testFixed();
    for (int i = 0; i < 6; i++) begin
      pixel("R2", 2'b00, i * 37, i * 53, i * 11);
      pixel("R3", 2'b11, i * 41, i * 29, i * 7);
    end
  endtask

  task automatic testTables();
    writeByte(1'b0, 3, 1'b0, 8'hC3);
    writeByte(1'b0, 3, 1'b1, 8'hA5);
    writeByte(1'b1, 3, 1'b0, 8'h3C);
    writeByte(1'b1, 3, 1'b1, 8'h5A);
    for (int i = 0; i < 16; i++) begin
      pixel("R4", 2'b01, i / 4, i % 4, 3);
      pixel("R4", 2'b10, i / 4, i % 4, 3);
    end
    // other phases still empty, frame 19 aliases phase 3
    pixel("R5", 2'b01, 0, 0, 4);
    pixel("R5", 2'b01, 0, 0, 19);
    pixel("R5", 2'b10, 3, 2, 243);
    // large counters fold modulo 4
    pixel("R6", 2'b01, 6, 9, 3);
    pixel("R6", 2'b10, 257, 1022, 3);
    pixel("R6", 2'b01, 511, 1023, 35);
  endtask

  task automatic testBytes();
    writeByte(1'b1, 7, 1'b0, 8'h01);
    pixel("R7", 2'b10, 0, 0, 7);
    pixel("R7", 2'b10, 3, 3, 7);
    writeByte(1'b1, 7, 1'b1, 8'h80);
    pixel("R7", 2'b10, 3, 3, 7);
    pixel("R7", 2'b01, 3, 3, 7);
  endtask

  task automatic testIgnoredWrite();
    @(negedge clk);
    wrEn = 1'b0; wrAddr = {1'b0, 4'd3, 1'b0}; wrData = 8'hFF;
    @(negedge clk);
    wrAddr = '0; wrData = '0;
    pixel("R9", 2'b01, 0, 2, 3);
    pixel("R9", 2'b01, 1, 0, 3);
  endtask

  task automatic testSameEdge();
    // write and lookup on the same edge: old data seen, new data next
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {1'b0, 4'd9, 1'b0}; wrData = 8'h10;
    pixValid = 1'b1; pixCode = 2'b01; rowCnt = 9'd1; colCnt = 10'd0; frameCnt = 8'd9;
    @(negedge clk);
    wrEn = 1'b0;
    check("R10", dotOut, 1'b0);
    model[0][9][7:0] = 8'h10;
    @(negedge clk);
    pixValid = 1'b0;
    check("R10", dotOut, 1'b1);
    @(negedge clk);
    check("R8", dotValid, 1'b0);
    check("R8", dotOut, 1'b0);
  endtask

  initial begin
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 16; p++) model[t][p] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFixed();
    testTables();
    testBytes();
    testIgnoredWrite();
    testSameEdge();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule